// File: doc/BRIEF.md
# Serial Receive Queue with Overflow Policy

This block sits between a serial shift engine and a host read port. Each received frame arrives as a 32-bit word with a one-cycle valid strobe. It is stored in a small ring buffer. The host reads the oldest word at the head output and removes it with a pop strobe. The current occupancy and the index of the next entry to be popped are both visible as status, zero-extended to a common status width.

A data-present flag follows occupancy. A sticky overflow flag records any frame that arrived when there was no room. A policy input selects what happens to such a frame: it is either thrown away, or it replaces the most recently stored entry. A one-cycle clear strobe empties the queue. A disable input shrinks the queue to a single slot, so it behaves as a plain holding register.

The data-present condition, qualified by an enable, is steered to either an interrupt line or a DMA request line by a route-select input. The overflow flag drives a separate interrupt with its own enable. The overflow flag is cleared by writing 1 to it, which the host does by pulsing a clear input.

Top module: `spi_rx_queue`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), occupancy, pop index, both flags and all three request outputs are 0.
- R2: Accepted frames leave in arrival order. head_data shows the oldest stored word. Each pop of a non-empty queue lowers occupancy by one and advances the pop index by one, wrapping from DEPTH-1 to 0.
- R3: The data-present flag is 1 exactly when occupancy is non-zero.
- R4: A frame that arrives while the queue is full, with no accepted pop in the same cycle, sets the overflow flag and leaves occupancy unchanged.
- R5: With the overwrite policy input at 0, an overflowing frame is discarded and every stored word is left intact.
- R6: With the overwrite policy input at 1, an overflowing frame replaces the most recently stored word.
- R7: A frame and a pop in the same cycle on a full queue are both accepted. The overflow flag stays 0 and occupancy is unchanged.
- R8: The clear strobe sets occupancy and both ring indices to 0 on the next edge. It overrides any frame or pop in the same cycle, and that frame does not count as an overflow. It leaves the overflow flag as it was.
- R9: With the disable input at 1 the capacity is one entry, so a second frame arriving before a pop overflows.
- R10: The overflow flag stays set until an overflow-clear pulse. If a new overflow occurs in the same cycle as the clear pulse, the flag stays set.
- R11: With the drain enable at 1, data present raises irq_drain when the route select is 0 and dma_drain when it is 1. With the enable at 0 neither output is raised, and the two are never high together.
- R12: irq_ovf equals the overflow flag ANDed with its enable.
- R13: A pop on an empty queue is ignored: occupancy and pop index are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_valid | input | 1 | Received frame strobe |
| frame_data | input | 32 | Received frame word |
| pop | input | 1 | Host removes the head word |
| head_data | output | 32 | Oldest stored word (0 when empty) |
| cfg_overwrite | input | 1 | Overflow policy: 1 replaces the newest entry, 0 discards |
| cfg_single | input | 1 | Disable queueing; capacity becomes one entry |
| clear_q | input | 1 | Empty the queue (pulse) |
| ovf_clr | input | 1 | Write-1 clear of the overflow flag |
| drain_en | input | 1 | Enable for the drain request |
| drain_route | input | 1 | Drain route: 0 interrupt, 1 DMA |
| ovf_en | input | 1 | Enable for the overflow interrupt |
| occupancy | output | 4 | Stored entry count |
| pop_index | output | 4 | Index of the next entry to be popped |
| data_present | output | 1 | Queue is not empty |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq_drain | output | 1 | Drain interrupt request |
| dma_drain | output | 1 | Drain DMA request |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
A wrong occupancy count shows up on the status output at the next edge. It also shows on the data-present flag and the drain request lines. A skipped or doubled index shows up as out-of-order or repeated words at head_data on the next pop. An overwrite that lands in the wrong slot stays hidden until that slot reaches the head, so the bench drains the whole queue after each overflow scenario. A missed overflow detection appears one cycle later as a clear flag and a changed occupancy.

// File: rtl/rxq_pkg.sv
// Shared types for the receive queue.
// Assumes: nothing beyond the standard language.
package rxq_pkg;
    typedef enum logic {
        ROUTE_IRQ = 1'b0,
        ROUTE_DMA = 1'b1
    } drain_route_e;
endpackage

// File: rtl/rxq_store.sv
// Storage array of the receive queue, with one register word per entry.
// Assumes: wr_idx and rd_idx are below DEPTH. The controller guarantees at most
// one write per cycle.
module rxq_store #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] slot [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        // Load this entry when it is the write target.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot[i] <= '0;
            else if (wr_en && (wr_idx == PTR_W'(i)))
                slot[i] <= wr_data;
        end
    end

    // Select the entry at the read index.
    assign rd_data = slot[rd_idx];
endmodule

// File: rtl/rxq_ctrl.sv
// Occupancy, ring indices and the accept/overflow decision of the receive queue.
// Assumes: DEPTH fits in CNT_W bits. cfg_single changes only while the queue
// holds at most one entry.
module rxq_ctrl #(
    parameter int DEPTH = 4,
    parameter int CNT_W = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_valid,
    input  logic             pop,
    input  logic             cfg_overwrite,
    input  logic             cfg_single,
    input  logic             clear_q,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_idx,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] count,
    output logic             ovf_evt
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0] wr_ptr;
    logic [CNT_W-1:0] cap;
    logic             empty, full, take_pop, take_push, room;

    // Decide what happens to this cycle's frame and pop.
    always_comb begin
        cap       = cfg_single ? CNT_W'(1) : CNT_W'(DEPTH);
        empty     = (count == '0);
        full      = (count >= cap);
        take_pop  = pop && !empty && !clear_q;
        room      = !full || take_pop;
        take_push = frame_valid && !clear_q && room;
        ovf_evt   = frame_valid && !clear_q && !room;
        wr_en     = take_push || (ovf_evt && cfg_overwrite && !empty);
        if (take_push)
            wr_idx = wr_ptr;
        else
            wr_idx = (wr_ptr == '0) ? LAST : wr_ptr - PTR_W'(1);
    end

    // Advance the indices and update occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_q) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (take_push)
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + PTR_W'(1);
            if (take_pop)
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + PTR_W'(1);
            count <= count + CNT_W'(take_push) - CNT_W'(take_pop);
        end
    end

    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    assert_full_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && !pop && !clear_q && count == cap && !cfg_single) |=> $stable(count));

    assert_pop_empty_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !frame_valid && !clear_q && count == '0) |=> (count == '0) && $stable(rd_ptr));

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear_q |=> (count == '0) && (rd_ptr == '0));
endmodule

// File: rtl/rxq_flags.sv
// Sticky overflow flag and request steering for the receive queue.
// Assumes: ovf_evt is a single-cycle event from the controller.
module rxq_flags
    import rxq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ovf_evt,
    input  logic ovf_clr,
    input  logic nonempty,
    input  logic drain_en,
    input  logic drain_route,
    input  logic ovf_en,
    output logic ovf_flag,
    output logic irq_drain,
    output logic dma_drain,
    output logic irq_ovf
);
    drain_route_e route;

    // Set the flag on overflow; a new event wins over a clear pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf_flag <= 1'b0;
        else if (ovf_evt)
            ovf_flag <= 1'b1;
        else if (ovf_clr)
            ovf_flag <= 1'b0;
    end

    // Send the drain request to the selected line; gate the overflow interrupt.
    always_comb begin
        route     = drain_route_e'(drain_route);
        irq_drain = nonempty && drain_en && (route == ROUTE_IRQ);
        dma_drain = nonempty && drain_en && (route == ROUTE_DMA);
        irq_ovf   = ovf_flag && ovf_en;
    end

    assert_route_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_drain && dma_drain));

    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    assert_ovf_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> ovf_flag);
endmodule

// File: rtl/spi_rx_queue.sv
// Receive queue top: storage, controller and flag/request logic.
// Assumes: the shift engine gives at most one frame per cycle and the host
// gives at most one pop per cycle.
module spi_rx_queue #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_valid,
    input  logic [DATA_W-1:0] frame_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head_data,
    input  logic              cfg_overwrite,
    input  logic              cfg_single,
    input  logic              clear_q,
    input  logic              ovf_clr,
    input  logic              drain_en,
    input  logic              drain_route,
    input  logic              ovf_en,
    output logic [CNT_W-1:0]  occupancy,
    output logic [CNT_W-1:0]  pop_index,
    output logic              data_present,
    output logic              ovf_flag,
    output logic              irq_drain,
    output logic              dma_drain,
    output logic              irq_ovf
);
    logic              wr_en, ovf_evt;
    logic [PTR_W-1:0]  wr_idx, rd_ptr;
    logic [CNT_W-1:0]  count;
    logic [DATA_W-1:0] rd_word;

    rxq_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .pop(pop),
        .cfg_overwrite(cfg_overwrite), .cfg_single(cfg_single), .clear_q(clear_q),
        .wr_en(wr_en), .wr_idx(wr_idx), .rd_ptr(rd_ptr), .count(count),
        .ovf_evt(ovf_evt)
    );

    rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(frame_data), .rd_idx(rd_ptr), .rd_data(rd_word)
    );

    rxq_flags u_flags (
        .clk(clk), .rst_n(rst_n), .ovf_evt(ovf_evt), .ovf_clr(ovf_clr),
        .nonempty(data_present), .drain_en(drain_en), .drain_route(drain_route),
        .ovf_en(ovf_en), .ovf_flag(ovf_flag), .irq_drain(irq_drain),
        .dma_drain(dma_drain), .irq_ovf(irq_ovf)
    );

    // Expose status and the head word (0 when empty).
    always_comb begin
        occupancy    = count;
        pop_index    = CNT_W'(rd_ptr);
        data_present = (count != '0);
        head_data    = data_present ? rd_word : '0;
    end

    assert_present_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && !clear_q) |=> data_present);
endmodule

// File: tb/spi_rx_queue_test.sv
module spi_rx_queue_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_valid = 1'b0, pop = 1'b0, clear_q = 1'b0, ovf_clr = 1'b0;
    logic [31:0] frame_data = '0;
    logic        cfg_overwrite = 1'b0, cfg_single = 1'b0;
    logic        drain_en = 1'b0, drain_route = 1'b0, ovf_en = 1'b0;
    logic [31:0] head_data;
    logic [3:0]  occupancy, pop_index;
    logic        data_present, ovf_flag, irq_drain, dma_drain, irq_ovf;
    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    spi_rx_queue uut (
        .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_data(frame_data),
        .pop(pop), .head_data(head_data), .cfg_overwrite(cfg_overwrite),
        .cfg_single(cfg_single), .clear_q(clear_q), .ovf_clr(ovf_clr),
        .drain_en(drain_en), .drain_route(drain_route), .ovf_en(ovf_en),
        .occupancy(occupancy), .pop_index(pop_index), .data_present(data_present),
        .ovf_flag(ovf_flag), .irq_drain(irq_drain), .dma_drain(dma_drain),
        .irq_ovf(irq_ovf)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, sample 1 ns after the rising edge.
    task automatic step(logic v, logic [31:0] d, logic p, logic c, logic oc);
        @(negedge clk);
        frame_valid = v; frame_data = d; pop = p; clear_q = c; ovf_clr = oc;
        @(posedge clk);
        #1;
        frame_valid = 0; pop = 0; clear_q = 0; ovf_clr = 0;
    endtask

    task automatic push(logic [31:0] d); step(1, d, 0, 0, 0); endtask

    task automatic pop_expect(string req, logic [31:0] exp);
        chk(req, head_data, exp);
        step(0, 0, 1, 0, 0);
    endtask

    task automatic t_reset;
        chk("R1 occupancy", occupancy, 0);
        chk("R1 pop_index", pop_index, 0);
        chk("R1 flags", {data_present, ovf_flag}, 0);
        chk("R1 requests", {irq_drain, dma_drain, irq_ovf}, 0);
    endtask

    task automatic t_order;
        push(32'hA1); push(32'hB2); push(32'hC3);
        chk("R2 occupancy 3", occupancy, 3);
        chk("R3 present", data_present, 1);
        pop_expect("R2 head A", 32'hA1);
        chk("R2 index 1", pop_index, 1);
        chk("R2 occupancy 2", occupancy, 2);
        pop_expect("R2 head B", 32'hB2);
        pop_expect("R2 head C", 32'hC3);
        chk("R2 index 3", pop_index, 3);
        chk("R3 empty", data_present, 0);
        push(32'hD4);
        pop_expect("R2 wrap head", 32'hD4);
        chk("R2 index wraps", pop_index, 0);
    endtask

    task automatic t_pop_empty;
        step(0, 0, 1, 0, 0);
        chk("R13 occupancy", occupancy, 0);
        chk("R13 index", pop_index, 0);
    endtask

    task automatic t_clear;
        push(32'h11); push(32'h22); step(0, 0, 1, 0, 0);
        step(1, 32'h33, 1, 1, 0);
        chk("R8 occupancy", occupancy, 0);
        chk("R8 index", pop_index, 0);
        chk("R8 present", data_present, 0);
    endtask

    task automatic fill4(logic [31:0] base);
        for (int i = 0; i < 4; i++) push(base + i);
    endtask

    task automatic t_drop;
        cfg_overwrite = 0;
        fill4(32'h100);
        push(32'hBAD);
        chk("R4 ovf set", ovf_flag, 1);
        chk("R4 occupancy", occupancy, 4);
        for (int i = 0; i < 4; i++) pop_expect("R5 kept", 32'h100 + i);
        step(0, 0, 0, 0, 1);
        chk("R10 cleared", ovf_flag, 0);
    endtask

    task automatic t_overwrite;
        step(0, 0, 0, 1, 0);
        cfg_overwrite = 1;
        fill4(32'h200);
        push(32'hEEE);
        chk("R6 ovf set", ovf_flag, 1);
        chk("R6 occupancy", occupancy, 4);
        pop_expect("R6 e0", 32'h200);
        pop_expect("R6 e1", 32'h201);
        pop_expect("R6 e2", 32'h202);
        pop_expect("R6 replaced", 32'hEEE);
        cfg_overwrite = 0;
        step(0, 0, 0, 0, 1);
    endtask

    task automatic t_simul;
        fill4(32'h300);
        step(1, 32'h304, 1, 0, 0);
        chk("R7 no ovf", ovf_flag, 0);
        chk("R7 occupancy", occupancy, 4);
        for (int i = 1; i < 5; i++) pop_expect("R7 order", 32'h300 + i);
    endtask

    task automatic t_single;
        step(0, 0, 0, 1, 0);
        cfg_single = 1;
        push(32'h41);
        chk("R9 occupancy 1", occupancy, 1);
        push(32'h42);
        chk("R9 ovf", ovf_flag, 1);
        chk("R9 occupancy held", occupancy, 1);
        step(1, 32'h43, 0, 0, 1);
        chk("R10 set wins", ovf_flag, 1);
        pop_expect("R9 head", 32'h41);
        chk("R9 empty", occupancy, 0);
        cfg_single = 0;
    endtask

    task automatic t_requests;
        push(32'h55);
        drain_en = 0; #1;
        chk("R11 disabled", {irq_drain, dma_drain}, 2'b00);
        drain_en = 1; drain_route = 0; #1;
        chk("R11 to irq", {irq_drain, dma_drain}, 2'b10);
        drain_route = 1; #1;
        chk("R11 to dma", {irq_drain, dma_drain}, 2'b01);
        ovf_en = 0; #1;
        chk("R12 masked", irq_ovf, 0);
        ovf_en = 1; #1;
        chk("R12 raised", irq_ovf, 1);
        step(0, 0, 0, 0, 1);
        chk("R12 after clear", irq_ovf, 0);
        step(0, 0, 1, 0, 0);
        chk("R11 empty no dma", dma_drain, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk); rst_n = 1;
        t_order();
        t_pop_empty();
        t_clear();
        t_drop();
        t_overwrite();
        t_simul();
        t_single();
        t_requests();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule